// File: doc/BRIEF.md
# Scan Chain with Per-Cell Hold Stages for Two-Vector Delay Test

This block is a parameterized scan chain in which each scan flip-flop feeds the logic under test through its own hold stage. Each scan flip-flop loads either its functional input (capture) or the previous cell's value (shift), as the shift enable selects. A test-control input chooses between normal operation and test operation. In normal operation the hold stages are bypassed and never load. In test operation a hold request freezes the values that the logic under test sees.

A delay test needs two vectors applied one after the other. The first vector sets up the path and the second launches the transition that is then captured. Without hold stages, shifting in the second vector would disturb the first vector at the logic inputs. So the second vector could only be the logic's response to the first, or the first vector moved by one position. With this chain the first vector is launched and then frozen while a fully arbitrary second vector is shifted in behind it. Dropping the hold request presents the second vector to the logic, and the following capture edge records the response.

The operating mode is decoded by a small combinational mode decoder. The flop mode has two states: `FF_CAPTURE` and `FF_SHIFT`. The hold mode has three states:
- `HS_BYPASS`: test control high.
- `HS_TRACK`: test control low and hold low.
- `HS_FROZEN`: test control low and hold high.

The transitions between hold modes are:
- `HS_TRACK` to `HS_FROZEN` when hold rises.
- `HS_FROZEN` to `HS_TRACK` when hold falls; this launches the vector.
- Any state to `HS_BYPASS` when test control rises.

Top module: `esc_chain`

## Requirements
- R1: A synchronous active-low reset clears every scan flip-flop and every hold stage to 0, so `func_q` and `scan_out` read 0 after a reset edge, whatever the hold request is.
- R2: With `scan_en` = 0, each clock edge loads cell i with `func_d[i]`.
- R3: With `scan_en` = 1, each clock edge loads cell 0 with `scan_in` and cell i with cell i-1. `scan_out` always shows the scan flip-flop of the last cell (index CHAIN_LEN-1), so a vector shifted in most-significant bit first lands with bit i in cell i.
- R4: With `test_ctl` = 1 (normal), `func_q` equals the scan flip-flop contents and `hold_req` has no effect.
- R5: With `test_ctl` = 1, the hold stages never load. The value they held before normal operation is still what `func_q` shows once the chain enters `HS_FROZEN`.
- R6: With `test_ctl` = 0 and `hold_req` = 0, the hold stages are transparent: `func_q` equals the scan flip-flops and the hold stages follow them on every edge.
- R7: With `test_ctl` = 0 and `hold_req` = 1, `func_q` stays at the held vector across any number of shift or capture edges, while the scan flip-flops and `scan_out` keep advancing.
- R8: Lowering `hold_req` in test mode makes `func_q` show the current scan flip-flop contents in the same cycle, before the next clock edge. This launches an arbitrary second vector.
- R9: Launch by shift: with the hold stages transparent, one shift edge turns a loaded vector V into {V[CHAIN_LEN-2:0], scan_in} at `func_q`.
- R10: Launch by capture: with the hold stages transparent, one capture edge turns a loaded vector V into the logic's response to V at `func_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_ctl | input | 1 | 1 = normal operation (hold stages bypassed), 0 = test operation |
| hold_req | input | 1 | In test operation, 1 freezes the hold stages |
| scan_en | input | 1 | 1 = shift along the chain, 0 = capture functional data |
| scan_in | input | 1 | Serial data into cell 0 |
| func_d | input | CHAIN_LEN | Functional inputs, one per cell (outputs of the logic under test) |
| func_q | output | CHAIN_LEN | Values driven into the logic under test |
| scan_out | output | 1 | Serial data out of the last scan flip-flop |

## Verification
Shifting and holding happen in the same cycle. A second vector moves through the scan flip-flops while the hold stages keep the first vector at the logic inputs. The bench provokes this by freezing a launched first vector and then applying a full chain length of shift edges. After every edge it checks that `func_q` is unchanged and that `scan_out` steps through the first vector bit by bit. It also applies capture edges while the stages are frozen. It then lowers the hold request and checks that the second vector appears before the next edge and that the capture response follows one edge later.

// File: rtl/esc_pkg.sv
package esc_pkg;

    // Operating mode of each scan flip-flop.
    typedef enum logic {
        FF_CAPTURE = 1'b0,
        FF_SHIFT   = 1'b1
    } ff_mode_e;

    // Operating mode of each hold stage.
    typedef enum logic [1:0] {
        HS_BYPASS = 2'd0,
        HS_TRACK  = 2'd1,
        HS_FROZEN = 2'd2
    } hold_mode_e;

endpackage

// File: rtl/esc_mode_dec.sv
module esc_mode_dec
    import esc_pkg::*;
(
    input  logic       test_ctl,
    input  logic       hold_req,
    input  logic       scan_en,
    output ff_mode_e   ff_mode,
    output hold_mode_e hold_mode
);

    // The flop mode follows the shift enable directly.
    always_comb begin
        ff_mode = scan_en ? FF_SHIFT : FF_CAPTURE;
    end

    // Hold stage mode: normal operation bypasses the stage; test operation
    // either tracks the flop or freezes on the hold request.
    always_comb begin
        unique case ({test_ctl, hold_req})
            2'b00:   hold_mode = HS_TRACK;
            2'b01:   hold_mode = HS_FROZEN;
            2'b10:   hold_mode = HS_BYPASS;
            2'b11:   hold_mode = HS_BYPASS;
            default: hold_mode = HS_BYPASS;
        endcase
    end

endmodule

// File: rtl/esc_cell.sv
module esc_cell
    import esc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ff_mode_e   ff_mode,
    input  hold_mode_e hold_mode,
    input  logic       func_d,
    input  logic       scan_d,
    output logic       ff_q,
    output logic       lat_q,
    output logic       logic_q
);

    logic ff_next;

    // Scan multiplexer in front of the flip-flop.
    always_comb begin
        unique case (ff_mode)
            FF_SHIFT:   ff_next = scan_d;
            FF_CAPTURE: ff_next = func_d;
            default:    ff_next = func_d;
        endcase
    end

    // Scan flip-flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ff_q <= 1'b0;
        end else begin
            ff_q <= ff_next;
        end
    end

    // Hold stage: loads the flop's next value only while tracking, so it
    // equals the flop after every tracking edge and stays quiet otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= 1'b0;
        end else if (hold_mode == HS_TRACK) begin
            lat_q <= ff_next;
        end
    end

    // Output selection toward the logic under test.
    always_comb begin
        unique case (hold_mode)
            HS_FROZEN: logic_q = lat_q;
            HS_TRACK:  logic_q = ff_q;
            HS_BYPASS: logic_q = ff_q;
            default:   logic_q = ff_q;
        endcase
    end

endmodule

// File: rtl/esc_chain.sv
module esc_chain
    import esc_pkg::*;
#(
    parameter int CHAIN_LEN = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 test_ctl,
    input  logic                 hold_req,
    input  logic                 scan_en,
    input  logic                 scan_in,
    input  logic [CHAIN_LEN-1:0] func_d,
    output logic [CHAIN_LEN-1:0] func_q,
    output logic                 scan_out
);

    localparam int LAST = CHAIN_LEN - 1;

    ff_mode_e             ff_mode;
    hold_mode_e           hold_mode;
    logic [CHAIN_LEN-1:0] ff_q;
    logic [CHAIN_LEN-1:0] lat_q;

    esc_mode_dec u_dec (
        .test_ctl  (test_ctl),
        .hold_req  (hold_req),
        .scan_en   (scan_en),
        .ff_mode   (ff_mode),
        .hold_mode (hold_mode)
    );

    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
        logic sd;
        if (i == 0) begin : g_head
            assign sd = scan_in;
        end else begin : g_link
            assign sd = ff_q[i-1];
        end

        esc_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .ff_mode   (ff_mode),
            .hold_mode (hold_mode),
            .func_d    (func_d[i]),
            .scan_d    (sd),
            .ff_q      (ff_q[i]),
            .lat_q     (lat_q[i]),
            .logic_q   (func_q[i])
        );
    end

    assign scan_out = ff_q[LAST];

endmodule

// File: rtl/esc_chain_chk.sv
module esc_chain_chk #(
    parameter int CHAIN_LEN = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 test_ctl,
    input logic                 hold_req,
    input logic                 scan_en,
    input logic                 scan_in,
    input logic [CHAIN_LEN-1:0] func_d,
    input logic [CHAIN_LEN-1:0] func_q,
    input logic                 scan_out,
    input logic [CHAIN_LEN-1:0] ff_q,
    input logic [CHAIN_LEN-1:0] lat_q
);

    localparam int PRE = CHAIN_LEN - 2;

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (ff_q == '0 && lat_q == '0 && scan_out == 1'b0));

    // R2
    p_capture_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |=> (ff_q == $past(func_d)));

    // R3
    p_shift_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> (scan_out == $past(ff_q[PRE]) && ff_q[0] == $past(scan_in)));

    // R4
    p_bypass_view_r4: assert property (@(posedge clk) disable iff (!rst_n)
        test_ctl |-> (func_q == ff_q));

    // R5
    p_quiet_normal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        test_ctl |=> $stable(lat_q));

    // R6
    p_track_view_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_ctl && !hold_req) |=> (lat_q == ff_q));

    // R7
    p_frozen_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_ctl && hold_req && $past(!test_ctl && hold_req) && $past(rst_n))
            |-> $stable(func_q));

endmodule

bind esc_chain esc_chain_chk #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .test_ctl (test_ctl),
    .hold_req (hold_req),
    .scan_en  (scan_en),
    .scan_in  (scan_in),
    .func_d   (func_d),
    .func_q   (func_q),
    .scan_out (scan_out),
    .ff_q     (ff_q),
    .lat_q    (lat_q)
);

// File: tb/esc_chain_test.sv
`timescale 1ns/1ps
module esc_chain_test;

    localparam int N = 8;
    localparam logic [N-1:0] MASK = 8'h3C;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         test_ctl = 1'b1;
    logic         hold_req = 1'b0;
    logic         scan_en = 1'b0;
    logic         scan_in = 1'b0;
    logic [N-1:0] func_d;
    logic [N-1:0] func_q;
    logic         scan_out;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    // Logic under test model: rotate left by one and invert some bits.
    function automatic logic [N-1:0] resp(input logic [N-1:0] v);
        return {v[N-2:0], v[N-1]} ^ MASK;
    endfunction

    assign func_d = resp(func_q);

    esc_chain #(.CHAIN_LEN(N)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_ctl (test_ctl),
        .hold_req (hold_req),
        .scan_en  (scan_en),
        .scan_in  (scan_in),
        .func_d   (func_d),
        .func_q   (func_q),
        .scan_out (scan_out)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_vec(input string req, input logic [N-1:0] act,
                             input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Shift a vector in, most-significant bit first.
    task automatic shift_vec(input logic [N-1:0] v);
        for (int i = N - 1; i >= 0; i--) begin
            scan_en = 1'b1;
            scan_in = v[i];
            tick();
        end
    endtask

    task automatic t_reset_state();
        check_vec("R1 reset func_q", func_q, '0);
        check_bit("R1 reset scan_out", scan_out, 1'b0);
    endtask

    task automatic t_normal(input logic [N-1:0] v);
        test_ctl = 1'b1;
        hold_req = 1'b0;
        shift_vec(v);
        check_vec("R3 R4 shifted vector at func_q", func_q, v);
        for (int k = 0; k < N; k++) begin
            check_bit("R3 scan_out order", scan_out, v[N-1-k]);
            scan_en = 1'b1;
            scan_in = 1'b0;
            tick();
        end
        check_vec("R3 chain emptied", func_q, '0);
        shift_vec(v);
        scan_en = 1'b0;
        tick();
        check_vec("R2 capture loads func_d", func_q, resp(v));
        hold_req = 1'b1;
        shift_vec(~v);
        check_vec("R4 hold ignored in normal", func_q, ~v);
        scan_en = 1'b0;
        tick();
        check_vec("R4 capture with hold in normal", func_q, resp(~v));
    endtask

    task automatic t_quiet_latch();
        test_ctl = 1'b0;
        hold_req = 1'b1;
        #1;
        check_vec("R5 hold stage untouched by normal mode", func_q, '0);
    endtask

    task automatic t_hold_launch(input logic [N-1:0] v1, input logic [N-1:0] v2);
        test_ctl = 1'b0;
        hold_req = 1'b0;
        shift_vec(v1);
        check_vec("R6 transparent stage shows v1", func_q, v1);
        hold_req = 1'b1;
        for (int k = 0; k < N; k++) begin
            check_bit("R7 scan_out advances while frozen", scan_out, v1[N-1-k]);
            scan_en = 1'b1;
            scan_in = v2[N-1-k];
            tick();
            check_vec("R7 func_q frozen during shift", func_q, v1);
        end
        hold_req = 1'b0;
        #1;
        check_vec("R8 release launches v2", func_q, v2);
        scan_en = 1'b0;
        tick();
        check_vec("R10 capture after launch", func_q, resp(v2));
        hold_req = 1'b1;
        tick();
        check_vec("R7 func_q frozen during capture", func_q, resp(v2));
        hold_req = 1'b0;
        #1;
        check_vec("R8 release shows captured flops", func_q, resp(resp(v2)));
    endtask

    task automatic t_lfs(input logic [N-1:0] v, input logic b);
        test_ctl = 1'b0;
        hold_req = 1'b0;
        shift_vec(v);
        scan_en = 1'b1;
        scan_in = b;
        tick();
        check_vec("R9 launch by shift", func_q, {v[N-2:0], b});
    endtask

    task automatic t_lfc(input logic [N-1:0] v);
        test_ctl = 1'b0;
        hold_req = 1'b0;
        shift_vec(v);
        scan_en = 1'b0;
        tick();
        check_vec("R10 launch by capture", func_q, resp(v));
        tick();
        check_vec("R10 second capture", func_q, resp(resp(v)));
    endtask

    task automatic t_reset_frozen();
        test_ctl = 1'b0;
        hold_req = 1'b0;
        shift_vec(8'hC3);
        hold_req = 1'b1;
        rst_n = 1'b0;
        tick();
        check_vec("R1 reset clears frozen stage", func_q, '0);
        check_bit("R1 reset clears scan_out", scan_out, 1'b0);
        rst_n = 1'b1;
        hold_req = 1'b0;
        #1;
        check_vec("R1 flops cleared after release", func_q, '0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_normal(8'hB4);
        t_quiet_latch();
        t_hold_launch(8'h5A, 8'h0F);
        t_hold_launch(8'hFF, 8'h00);
        t_hold_launch(8'h81, 8'h7E);
        t_lfs(8'h96, 1'b1);
        t_lfs(8'h3D, 1'b0);
        t_lfc(8'hE1);
        t_reset_frozen();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule